// File: doc/BRIEF.md
# Serial Result Transmitter with Power-On Clock Mode Selection

This block models the output side of a converter that sends its results over two wires: a generated serial clock and a serial data line. It is used in testing, as a stand-in for the converter that a receiver is developed against. After reset a power-on wait runs. At the end of that wait the block reads the clock line, which a weak pull-up holds high unless something outside holds it low. The line level picks the timing mode. In internal-clock mode the block then runs conversion periods back to back with no select input. After each period it clocks out a 24-bit frame. The frame starts with an end-of-conversion flag bit and continues with the result word, which is taken from a parallel input.

During each conversion both lines are held high, so the clock line also acts as a busy indicator. When the result is ready, both lines drop low in the same cycle. The block then makes 24 clock pulses. The data line changes only on falling clock edges, so a receiver can capture each bit on a rising edge. The data line goes high on the 24th rising edge, and the next conversion starts at once. In external-clock mode the block does not drive the clock line. It stays idle and reports that mode on a status output.

Top module: `serial_result_tx`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `sck_o`=1, `sdo_o`=1, `sck_oe_o`=0 and `ext_mode_o`=0.
- R2: The mode is decided at the POR_CYCLES-th rising clock edge after `rst` is released. Until then `sck_oe_o`=0, `ext_mode_o`=0, `sck_o`=1 and `sdo_o`=1.
- R3: `sck_sense_i` is sampled only at the edge named in R2. A 1 selects internal-clock mode (`sck_oe_o`=1 from that edge). A 0 selects external-clock mode (`ext_mode_o`=1, `sck_oe_o`=0, `sck_o`=1, `sdo_o`=1). The chosen mode holds until reset, and later changes on `sck_sense_i` have no effect.
- R4: In internal-clock mode each conversion keeps `sck_o` and `sdo_o` high for exactly CONV_CYCLES cycles. The first conversion starts at the mode-selection edge.
- R5: At the end of a conversion, `sck_o` and `sdo_o` go low in the same cycle.
- R6: A frame has 24 rising edges on `sck_o`, and each low phase and each high phase lasts HALF_CYCLES cycles. `sdo_o` is constant while `sck_o` is high or low and changes only when `sck_o` falls. Bit order: first the end-of-conversion flag (0), then `sample_i` from bit 22 down to bit 0.
- R7: `sample_i` is captured in the cycle the conversion ends. Changes to `sample_i` during the frame do not alter that frame.
- R8: On the 24th rising edge of `sck_o`, `sdo_o` goes high in the same cycle and the next conversion begins with `sck_o` high. Frames repeat with no select input.
- R9: Asserting `rst` in the middle of a frame returns all outputs to the R1 state after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (start of power-on) |
| sck_sense_i | input | 1 | Level read on the clock line (pull-up high unless held low) |
| sample_i | input | FRAME_BITS-1 | Result word to send, MSB first |
| sck_o | output | 1 | Generated serial clock / busy level |
| sck_oe_o | output | 1 | High when the block drives the clock line (internal mode) |
| sdo_o | output | 1 | Serial data output |
| ext_mode_o | output | 1 | High when external-clock mode was selected |

## Verification
The bench builds the block with POR_CYCLES=12, CONV_CYCLES=20, HALF_CYCLES=2 and the default 24-bit frame. These values keep the power-on wait and each conversion short. Many frames, several resets and both mode decisions therefore fit in a short run, and each duration can be counted cycle by cycle. A half period of two cycles makes the phase counter wrap inside every phase, not on every cycle. The sense input is switched at the very last cycle of the power-on wait, and the bench also runs long after an external-mode decision.

// File: rtl/srtx_pkg.sv
package srtx_pkg;

    // Sequencer phases in internal-clock mode
    typedef enum logic [1:0] {
        PH_CONV = 2'd0,   // conversion in progress, both lines high
        PH_LOW  = 2'd1,   // serial clock low half
        PH_HIGH = 2'd2    // serial clock high half
    } seq_phase_e;

    // Outcome of the power-on mode decision
    typedef enum logic [1:0] {
        MODE_WAIT = 2'd0,
        MODE_INT  = 2'd1,
        MODE_EXT  = 2'd2
    } clk_mode_e;

    // Value of the leading status bit of every frame (result ready)
    localparam logic EOC_FLAG = 1'b0;

    // Width of a counter that must hold values 0..n
    function automatic int cnt_width(input int n);
        int w;
        w = $clog2(n + 1);
        return (w < 1) ? 1 : w;
    endfunction

endpackage

// File: rtl/srtx_por.sv
module srtx_por
    import srtx_pkg::*;
#(
    parameter int POR_CYCLES = 50000
) (
    input  logic clk,
    input  logic rst,
    input  logic sense_i,
    output logic run_o,
    output logic ext_o
);
    localparam int             W    = cnt_width(POR_CYCLES);
    localparam logic [W-1:0]   LAST = W'(POR_CYCLES - 1);
    localparam logic [W-1:0]   ONE  = W'(1);

    clk_mode_e      mode_q;
    logic [W-1:0]   cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_WAIT;
            cnt_q  <= '0;
        end else if (mode_q == MODE_WAIT) begin
            if (cnt_q == LAST) begin
                mode_q <= sense_i ? MODE_INT : MODE_EXT;
            end else begin
                cnt_q <= cnt_q + ONE;
            end
        end
    end

    assign run_o = (mode_q == MODE_INT);
    assign ext_o = (mode_q == MODE_EXT);

endmodule

// File: rtl/srtx_seq.sv
module srtx_seq
    import srtx_pkg::*;
#(
    parameter int CONV_CYCLES = 100000,
    parameter int HALF_CYCLES = 8,
    parameter int FRAME_BITS  = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic load_o,
    output logic shift_o,
    output logic frame_o,
    output logic sck_o
);
    localparam int           CW    = cnt_width(CONV_CYCLES);
    localparam int           HW    = cnt_width(HALF_CYCLES);
    localparam int           BW    = cnt_width(FRAME_BITS);
    localparam logic [CW-1:0] CLAST = CW'(CONV_CYCLES - 1);
    localparam logic [HW-1:0] HLAST = HW'(HALF_CYCLES - 1);
    localparam logic [BW-1:0] BLAST = BW'(FRAME_BITS - 1);
    localparam logic [CW-1:0] CONE  = CW'(1);
    localparam logic [HW-1:0] HONE  = HW'(1);
    localparam logic [BW-1:0] BONE  = BW'(1);

    seq_phase_e     phase_q;
    logic [CW-1:0]  ccnt_q;
    logic [HW-1:0]  hcnt_q;
    logic [BW-1:0]  bit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_CONV;
            ccnt_q  <= '0;
            hcnt_q  <= '0;
            bit_q   <= '0;
        end else if (run_i) begin
            unique case (phase_q)
                PH_CONV: begin
                    if (ccnt_q == CLAST) begin
                        ccnt_q  <= '0;
                        hcnt_q  <= '0;
                        bit_q   <= '0;
                        phase_q <= PH_LOW;
                    end else begin
                        ccnt_q <= ccnt_q + CONE;
                    end
                end
                PH_LOW: begin
                    if (hcnt_q == HLAST) begin
                        hcnt_q  <= '0;
                        phase_q <= (bit_q == BLAST) ? PH_CONV : PH_HIGH;
                    end else begin
                        hcnt_q <= hcnt_q + HONE;
                    end
                end
                PH_HIGH: begin
                    if (hcnt_q == HLAST) begin
                        hcnt_q  <= '0;
                        bit_q   <= bit_q + BONE;
                        phase_q <= PH_LOW;
                    end else begin
                        hcnt_q <= hcnt_q + HONE;
                    end
                end
                default: phase_q <= PH_CONV;
            endcase
        end
    end

    assign load_o  = run_i && (phase_q == PH_CONV) && (ccnt_q == CLAST);
    assign shift_o = run_i && (phase_q == PH_HIGH) && (hcnt_q == HLAST);
    assign frame_o = (phase_q == PH_LOW) || (phase_q == PH_HIGH);
    assign sck_o   = (phase_q != PH_LOW);

endmodule

// File: rtl/srtx_shreg.sv
module srtx_shreg
    import srtx_pkg::*;
#(
    parameter int FRAME_BITS = 24
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load_i,
    input  logic                  shift_i,
    input  logic                  frame_i,
    input  logic [FRAME_BITS-2:0] sample_i,
    output logic                  sdo_o
);
    logic [FRAME_BITS-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else if (load_i) begin
            sr_q <= {EOC_FLAG, sample_i};
        end else if (shift_i) begin
            sr_q <= {sr_q[FRAME_BITS-2:0], 1'b0};
        end
    end

    // Outside a frame the line idles high (busy / no result)
    assign sdo_o = frame_i ? sr_q[FRAME_BITS-1] : 1'b1;

endmodule

// File: rtl/serial_result_tx.sv
module serial_result_tx
    import srtx_pkg::*;
#(
    parameter int POR_CYCLES  = 50000,
    parameter int CONV_CYCLES = 100000,
    parameter int HALF_CYCLES = 8,
    parameter int FRAME_BITS  = 24
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sck_sense_i,
    input  logic [FRAME_BITS-2:0] sample_i,
    output logic                  sck_o,
    output logic                  sck_oe_o,
    output logic                  sdo_o,
    output logic                  ext_mode_o
);
    logic run;
    logic ext;
    logic load;
    logic shift;
    logic in_frame;
    logic seq_sck;

    srtx_por #(
        .POR_CYCLES (POR_CYCLES)
    ) u_por (
        .clk     (clk),
        .rst     (rst),
        .sense_i (sck_sense_i),
        .run_o   (run),
        .ext_o   (ext)
    );

    srtx_seq #(
        .CONV_CYCLES (CONV_CYCLES),
        .HALF_CYCLES (HALF_CYCLES),
        .FRAME_BITS  (FRAME_BITS)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .run_i   (run),
        .load_o  (load),
        .shift_o (shift),
        .frame_o (in_frame),
        .sck_o   (seq_sck)
    );

    srtx_shreg #(
        .FRAME_BITS (FRAME_BITS)
    ) u_shreg (
        .clk      (clk),
        .rst      (rst),
        .load_i   (load),
        .shift_i  (shift),
        .frame_i  (in_frame),
        .sample_i (sample_i),
        .sdo_o    (sdo_o)
    );

    assign sck_o      = seq_sck;
    assign sck_oe_o   = run;
    assign ext_mode_o = ext;

endmodule

// File: rtl/serial_result_tx_chk.sv
module serial_result_tx_chk #(
    parameter int CONV_CYCLES = 100000,
    parameter int HALF_CYCLES = 8
) (
    input logic clk,
    input logic rst,
    input logic sck_o,
    input logic sck_oe_o,
    input logic sdo_o,
    input logic ext_mode_o
);
    localparam int unsigned HALF_U = HALF_CYCLES;
    localparam int unsigned CONV_U = CONV_CYCLES;

    int unsigned low_run;
    int unsigned high_run;

    always_ff @(posedge clk) begin
        if (rst || sck_o || !sck_oe_o) low_run <= 0;
        else                           low_run <= low_run + 1;
        if (rst || !sck_o || !sck_oe_o) high_run <= 0;
        else                            high_run <= high_run + 1;
    end

    AST_MODES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(ext_mode_o && sck_oe_o));                                          // R3
    AST_EXT_IDLE: assert property (@(posedge clk) disable iff (rst)
        ext_mode_o |-> (sck_o && sdo_o && !sck_oe_o));                      // R3
    AST_EXT_STICKY: assert property (@(posedge clk) disable iff (rst)
        ext_mode_o |=> ext_mode_o);                                          // R3
    AST_INT_STICKY: assert property (@(posedge clk) disable iff (rst)
        sck_oe_o |=> sck_oe_o);                                              // R3
    AST_POR_LINES_HIGH: assert property (@(posedge clk) disable iff (rst)
        (!sck_oe_o && !ext_mode_o) |-> (sck_o && sdo_o));                    // R2
    AST_SDO_HOLD_LOW: assert property (@(posedge clk) disable iff (rst)
        (sck_oe_o && !sck_o && $past(!sck_o)) |-> $stable(sdo_o));           // R6
    AST_SDO_DROP_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (sck_oe_o && $fell(sdo_o)) |-> $fell(sck_o));                        // R5
    AST_LOW_PHASE_LEN: assert property (@(posedge clk) disable iff (rst)
        (sck_oe_o && $rose(sck_o)) |-> (low_run == HALF_U));                 // R6
    AST_HIGH_PHASE_LEN: assert property (@(posedge clk) disable iff (rst)
        (sck_oe_o && $fell(sck_o)) |-> (high_run == HALF_U || high_run == CONV_U)); // R4

endmodule

bind serial_result_tx serial_result_tx_chk #(
    .CONV_CYCLES (CONV_CYCLES),
    .HALF_CYCLES (HALF_CYCLES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sck_o      (sck_o),
    .sck_oe_o   (sck_oe_o),
    .sdo_o      (sdo_o),
    .ext_mode_o (ext_mode_o)
);

// File: tb/test_serial_result_tx.sv
module test_serial_result_tx;

    localparam int CLK_PERIOD = 10;
    localparam int POR_N      = 12;
    localparam int CONV_N     = 20;
    localparam int HALF_N     = 2;
    localparam int FB         = 24;
    localparam int NV         = 6;

    localparam logic [FB-2:0] VEC [0:NV-1] = '{
        23'h7FFFFF, 23'h000000, 23'h555555,
        23'h2AAAAA, 23'h400001, 23'h123456
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sck_sense_i = 1'b1;
    logic [FB-2:0] sample_i = '0;
    logic          sck_o, sck_oe_o, sdo_o, ext_mode_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_result_tx #(
        .POR_CYCLES  (POR_N),
        .CONV_CYCLES (CONV_N),
        .HALF_CYCLES (HALF_N),
        .FRAME_BITS  (FB)
    ) i_serial_result_tx (
        .clk         (clk),
        .rst         (rst),
        .sck_sense_i (sck_sense_i),
        .sample_i    (sample_i),
        .sck_o       (sck_o),
        .sck_oe_o    (sck_oe_o),
        .sdo_o       (sdo_o),
        .ext_mode_o  (ext_mode_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_idle(input string req);
        check(sck_o === 1'b1 && sdo_o === 1'b1 && sck_oe_o === 1'b0 && ext_mode_o === 1'b0,
              req, {28'd0, sck_o, sdo_o, sck_oe_o, ext_mode_o}, 32'hC);
    endtask

    // Counts further high samples until sck falls; the start sample is the first of CONV_N
    task automatic count_high(output int n, output bit sdo_hi);
        n = 0;
        sdo_hi = 1'b1;
        forever begin
            @(negedge clk);
            if (sck_o !== 1'b1) break;
            n++;
            if (sdo_o !== 1'b1) sdo_hi = 1'b0;
            if (n > 4 * CONV_N) break;
        end
    endtask

    // Called at the sample where sck has just fallen; returns at the 24th rise sample
    task automatic capture(output logic [FB-1:0] f, output bit timing_ok, output bit stable_ok, output bit tail_ok);
        logic b;
        int   lo, hi;
        f = '0; timing_ok = 1'b1; stable_ok = 1'b1; tail_ok = 1'b0;
        for (int k = 0; k < FB; k++) begin
            b  = sdo_o;
            lo = 1;
            forever begin
                @(negedge clk);
                if (sck_o === 1'b1) break;
                lo++;
                if (sdo_o !== b) stable_ok = 1'b0;
                if (lo > 100) break;
            end
            f[FB-1-k] = b;
            if (lo != HALF_N) timing_ok = 1'b0;
            if (k == FB - 1) begin
                tail_ok = (sdo_o === 1'b1);
            end else begin
                hi = 1;
                if (sdo_o !== b) stable_ok = 1'b0;
                forever begin
                    @(negedge clk);
                    if (sck_o !== 1'b1) break;
                    hi++;
                    if (sdo_o !== b) stable_ok = 1'b0;
                    if (hi > 100) break;
                end
                if (hi != HALF_N) timing_ok = 1'b0;
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R8 actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int            n;
        bit            hi_ok, t_ok, s_ok, tl_ok;
        logic [FB-1:0] f;

        sample_i = VEC[0];
        repeat (3) @(negedge clk);
        check_idle("R1 reset state");

        // Power-on wait, internal mode selected
        rst = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (sck_oe_o !== 1'b1 && n < 10 * POR_N);
        check(n == POR_N, "R2 power-on length", n, POR_N);
        check(ext_mode_o === 1'b0, "R3 internal mode, no ext flag", ext_mode_o, 0);

        count_high(n, hi_ok);
        check(n == CONV_N - 1 && hi_ok, "R4 first conversion length", n, CONV_N - 1);
        check(sdo_o === 1'b0 && sck_o === 1'b0, "R5 both lines low at end of conversion", {sck_o, sdo_o}, 0);

        // Vector table: one frame per entry, input changed right after capture (R7)
        for (int i = 0; i < NV; i++) begin
            sample_i = VEC[(i + 1) % NV];
            capture(f, t_ok, s_ok, tl_ok);
            check(f === {1'b0, VEC[i]}, "R6 R7 frame contents", f, {1'b0, VEC[i]});
            check(t_ok, "R6 phase lengths", t_ok, 1);
            check(s_ok, "R6 data steady between falling edges", s_ok, 1);
            check(tl_ok, "R8 data high on 24th rise", tl_ok, 1);
            count_high(n, hi_ok);
            check(n == CONV_N - 1 && hi_ok, "R8 R4 next conversion length", n, CONV_N - 1);
            check(sdo_o === 1'b0, "R5 data low at end of conversion", sdo_o, 0);
        end

        // Reset in the middle of a frame
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_idle("R9 reset mid-frame");

        // Sense low during power-on except the deciding cycle
        sck_sense_i = 1'b0;
        rst = 1'b0;
        repeat (POR_N - 1) @(negedge clk);
        check(sck_oe_o === 1'b0 && ext_mode_o === 1'b0, "R2 still waiting one cycle early",
              {sck_oe_o, ext_mode_o}, 0);
        sck_sense_i = 1'b1;
        @(negedge clk);
        check(sck_oe_o === 1'b1 && ext_mode_o === 1'b0, "R3 sense taken at last power-on cycle",
              {sck_oe_o, ext_mode_o}, 2);

        // Sense pulled low after selection: no effect
        sck_sense_i = 1'b0;
        sample_i = VEC[2];
        count_high(n, hi_ok);
        check(n == CONV_N - 1, "R4 conversion after late sense", n, CONV_N - 1);
        capture(f, t_ok, s_ok, tl_ok);
        check(f === {1'b0, VEC[2]}, "R3 sense ignored after selection", f, {1'b0, VEC[2]});
        check(sck_oe_o === 1'b1, "R3 still driving clock", sck_oe_o, 1);

        // External-clock mode
        rst = 1'b1;
        @(negedge clk);
        check_idle("R1 reset before ext mode");
        rst = 1'b0;
        repeat (POR_N) @(negedge clk);
        check(ext_mode_o === 1'b1 && sck_oe_o === 1'b0, "R3 external mode selected",
              {ext_mode_o, sck_oe_o}, 2);
        sck_sense_i = 1'b1;
        hi_ok = 1'b1;
        for (int c = 0; c < 3 * CONV_N; c++) begin
            @(negedge clk);
            if (!(sck_o === 1'b1 && sdo_o === 1'b1 && sck_oe_o === 1'b0 && ext_mode_o === 1'b1))
                hi_ok = 1'b0;
        end
        check(hi_ok, "R3 external mode stays idle", hi_ok, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule